// File: doc/BRIEF.md
# Multi-Cycle Instruction Control Sequencer

This block is the controller for a small non-pipelined processor core that takes several cycles per instruction. The datapath sends it the two opcode fields of the current instruction. In every cycle the sequencer drives one control word, which tells the datapath what to do in that cycle. The word covers register-file access, the operand and result register enables, the program counter and memory address register, the instruction byte latches, the ALU function, the memory write strobe and the operand multiplexers. Each instruction class has its own fixed run of control words. When a run ends, the sequencer chooses the next run from the opcode fields. The choice has two levels: first the primary field, and then, for primary code 11, the secondary field.

The outputs are decoded only from the registered state and the latched ALU function, so a control word is stable for the whole cycle. A branch is taken or not inside the datapath. The sequencer only raises a branch-enable in the target cycle and never sees the comparison result. Every control pin is a plain level; the block has no streaming interface.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the word is the fetch word: `inst1_en`, `pc_en` and `mar_en` are 1 and every other output is 0. One idle dispatch cycle follows, with every output at 0.
- R2: The opcode fields are sampled at the clock edge that ends a dispatch cycle. A dispatch cycle is the idle cycle after fetch or the last cycle of any run. `op1` 00, 01 or 10 selects the ALU run. `op1` 11 with `op2` 00 selects load, with 01 store, with 10 branch, and with 11 the reserved run.
- R3: The ALU run is 4 cycles. The words are: read ra into X1; read rb (`reg_sel`=01) into X2 and latch rc; load Y from the ALU and fetch; write rc. In the third cycle `alu_fn` equals the dispatched `op1` (00 add, 01 subtract, 10 nor).
- R4: The load run is 6 cycles. The words are: X1 from ra plus INST2 load; X2 from INST2 (`x2_sel`=1) plus rc latch; MAR from the ALU (`mar_sel`=1, add); Y from memory (`y_sel`=1) with PC/MAR advance; fetch; write rc.
- R5: The store run is 6 cycles: X1 plus INST2; X2 from INST2; MAR from the ALU with X2 from rc (`reg_sel`=10); `mem_we` with advance; fetch; idle. `mem_we` is high for one cycle only, right after the cycle that loads MAR from the ALU.
- R6: The branch run is 7 cycles: X1 plus INST2; X2 from rb; compare with `alu_fn`=01 while X1 loads PC (`x1_sel`=1) and X2 loads INST2; `branch_en` with `alu_fn`=00; advance; fetch; idle. The controller has no zero input.
- R7: In every cycle with `inst1_en`, `pc_en` and `mar_en` are also 1 and `mar_sel` is 0 (PC+1).
- R8: `reg_we` is only ever high with `reg_sel`=10 (rc).
- R9: Every output not named for a cycle is 0.
- R10: The reserved run is 3 cycles: advance, fetch, idle.
- R11: Opcode values present outside dispatch cycles change neither the current run nor the ALU function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op1 | input | 2 | Primary opcode field |
| op2 | input | 2 | Secondary opcode field |
| reg_we | output | 1 | Register-file write |
| reg_sel | output | 2 | Register field select: 00 ra, 01 rb, 10 rc |
| alu_fn | output | 2 | ALU function: 00 add, 01 sub, 10 nor |
| x1_en | output | 1 | X1 load enable |
| x2_en | output | 1 | X2 load enable |
| y_en | output | 1 | Y load enable |
| pc_en | output | 1 | PC load enable |
| mar_en | output | 1 | MAR load enable |
| inst1_en | output | 1 | First instruction byte load |
| inst2_en | output | 1 | Second instruction byte load |
| rc_en | output | 1 | rc field latch enable |
| mem_we | output | 1 | Memory write strobe |
| branch_en | output | 1 | Branch target load enable |
| x1_sel | output | 1 | X1 source: 0 register, 1 PC |
| x2_sel | output | 1 | X2 source: 0 register, 1 INST2 |
| mar_sel | output | 1 | MAR source: 0 PC+1, 1 ALU |
| y_sel | output | 1 | Y source: 0 ALU, 1 memory |

## Verification
Each control word depends only on the state register, so it changes one clock edge after the edge that entered the state. Opcodes take effect one edge after a dispatch cycle: the first word of the new run appears in the cycle after the opcodes were sampled. The bench drives opcodes and compares the full word at the falling edge, halfway between the edges, and places each row's opcodes in the half-cycle before the edge that samples them. Reset is asynchronous, so the fetch word is checked a short delay after `rst_n` falls, with no edge in between.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;

  localparam int OP_W  = 2;
  localparam int SEL_W = 2;
  localparam int FN_W  = 2;
  localparam int ST_W  = 5;

  localparam logic [FN_W-1:0]  FN_ADD = 2'd0;
  localparam logic [FN_W-1:0]  FN_SUB = 2'd1;
  localparam logic [FN_W-1:0]  FN_NOR = 2'd2;

  localparam logic [SEL_W-1:0] RS_A = 2'd0;
  localparam logic [SEL_W-1:0] RS_B = 2'd1;
  localparam logic [SEL_W-1:0] RS_C = 2'd2;

  localparam logic [OP_W-1:0]  OP1_EXT = 2'd3;
  localparam logic [OP_W-1:0]  OP2_LD  = 2'd0;
  localparam logic [OP_W-1:0]  OP2_ST  = 2'd1;
  localparam logic [OP_W-1:0]  OP2_BR  = 2'd2;

  typedef enum logic [ST_W-1:0] {
    S_FETCH, S_DISP,
    S_A0, S_A1, S_A2, S_A3,
    S_L0, S_L1, S_L2, S_L3, S_L4, S_L5,
    S_W0, S_W1, S_W2, S_W3, S_W4, S_W5,
    S_B0, S_B1, S_B2, S_B3, S_B4, S_B5, S_B6,
    S_V0, S_V1, S_V2
  } seq_state_e;

  typedef struct packed {
    logic             reg_we;
    logic [SEL_W-1:0] reg_sel;
    logic [FN_W-1:0]  alu_fn;
    logic             x1_en;
    logic             x2_en;
    logic             y_en;
    logic             pc_en;
    logic             mar_en;
    logic             inst1_en;
    logic             inst2_en;
    logic             rc_en;
    logic             mem_we;
    logic             branch_en;
    logic             x1_sel;
    logic             x2_sel;
    logic             mar_sel;
    logic             y_sel;
  } ctl_word_t;

endpackage

// File: rtl/ctlseq_next.sv
module ctlseq_next
  import ctlseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op1,
  input  logic [OP_W-1:0] op2,
  output seq_state_e      state,
  output logic [FN_W-1:0] fn_q
);

  seq_state_e nxt;
  logic       at_dispatch;

  function automatic seq_state_e pick(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    if (a != OP1_EXT)      return S_A0;
    else if (b == OP2_LD)  return S_L0;
    else if (b == OP2_ST)  return S_W0;
    else if (b == OP2_BR)  return S_B0;
    else                   return S_V0;
  endfunction

  always_comb begin
    at_dispatch = (state == S_DISP) || (state == S_A3) || (state == S_L5) ||
                  (state == S_W5)   || (state == S_B6) || (state == S_V2);
  end

  always_comb begin
    nxt = S_FETCH;
    if (at_dispatch) nxt = pick(op1, op2);
    else begin
      case (state)
        S_FETCH: nxt = S_DISP;
        S_A0:    nxt = S_A1;
        S_A1:    nxt = S_A2;
        S_A2:    nxt = S_A3;
        S_L0:    nxt = S_L1;
        S_L1:    nxt = S_L2;
        S_L2:    nxt = S_L3;
        S_L3:    nxt = S_L4;
        S_L4:    nxt = S_L5;
        S_W0:    nxt = S_W1;
        S_W1:    nxt = S_W2;
        S_W2:    nxt = S_W3;
        S_W3:    nxt = S_W4;
        S_W4:    nxt = S_W5;
        S_B0:    nxt = S_B1;
        S_B1:    nxt = S_B2;
        S_B2:    nxt = S_B3;
        S_B3:    nxt = S_B4;
        S_B4:    nxt = S_B5;
        S_B5:    nxt = S_B6;
        S_V0:    nxt = S_V1;
        S_V1:    nxt = S_V2;
        default: nxt = S_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      fn_q  <= FN_ADD;
    end else begin
      state <= nxt;
      if (at_dispatch && (op1 != OP1_EXT)) fn_q <= op1;
    end
  end

endmodule

// File: rtl/ctlseq_decode.sv
module ctlseq_decode
  import ctlseq_pkg::*;
(
  input  seq_state_e      state,
  input  logic [FN_W-1:0] fn_q,
  output ctl_word_t       w
);

  always_comb begin
    w = '0;
    case (state)
      S_FETCH, S_A2, S_L4, S_W4, S_B5, S_V1: begin
        w.inst1_en = 1'b1;
        w.pc_en    = 1'b1;
        w.mar_en   = 1'b1;
        if (state == S_A2) begin
          w.y_en   = 1'b1;
          w.alu_fn = fn_q;
        end
      end
      S_A0: w.x1_en = 1'b1;
      S_A1: begin
        w.x2_en   = 1'b1;
        w.reg_sel = RS_B;
        w.rc_en   = 1'b1;
      end
      S_A3, S_L5: begin
        w.reg_we  = 1'b1;
        w.reg_sel = RS_C;
      end
      S_L0, S_W0, S_B0: begin
        w.x1_en    = 1'b1;
        w.inst2_en = 1'b1;
      end
      S_L1, S_W1: begin
        w.x2_en  = 1'b1;
        w.x2_sel = 1'b1;
        w.rc_en  = (state == S_L1);
      end
      S_L2: begin
        w.mar_en  = 1'b1;
        w.mar_sel = 1'b1;
      end
      S_L3: begin
        w.y_en   = 1'b1;
        w.y_sel  = 1'b1;
        w.pc_en  = 1'b1;
        w.mar_en = 1'b1;
      end
      S_W2: begin
        w.mar_en  = 1'b1;
        w.mar_sel = 1'b1;
        w.x2_en   = 1'b1;
        w.reg_sel = RS_C;
      end
      S_W3: begin
        w.mem_we = 1'b1;
        w.pc_en  = 1'b1;
        w.mar_en = 1'b1;
      end
      S_B1: begin
        w.x2_en   = 1'b1;
        w.reg_sel = RS_B;
      end
      S_B2: begin
        w.alu_fn = FN_SUB;
        w.x1_en  = 1'b1;
        w.x1_sel = 1'b1;
        w.x2_en  = 1'b1;
        w.x2_sel = 1'b1;
      end
      S_B3: begin
        w.branch_en = 1'b1;
        w.alu_fn    = FN_ADD;
      end
      S_B4, S_V0: begin
        w.pc_en  = 1'b1;
        w.mar_en = 1'b1;
      end
      default: w = '0;
    endcase
  end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctlseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op1,
  input  logic [OP_W-1:0]  op2,
  output logic             reg_we,
  output logic [SEL_W-1:0] reg_sel,
  output logic [FN_W-1:0]  alu_fn,
  output logic             x1_en,
  output logic             x2_en,
  output logic             y_en,
  output logic             pc_en,
  output logic             mar_en,
  output logic             inst1_en,
  output logic             inst2_en,
  output logic             rc_en,
  output logic             mem_we,
  output logic             branch_en,
  output logic             x1_sel,
  output logic             x2_sel,
  output logic             mar_sel,
  output logic             y_sel
);

  seq_state_e      state;
  logic [FN_W-1:0] fn_q;
  ctl_word_t       w;

  ctlseq_next u_next (
    .clk   (clk),
    .rst_n (rst_n),
    .op1   (op1),
    .op2   (op2),
    .state (state),
    .fn_q  (fn_q)
  );

  ctlseq_decode u_dec (
    .state (state),
    .fn_q  (fn_q),
    .w     (w)
  );

  assign reg_we    = w.reg_we;
  assign reg_sel   = w.reg_sel;
  assign alu_fn    = w.alu_fn;
  assign x1_en     = w.x1_en;
  assign x2_en     = w.x2_en;
  assign y_en      = w.y_en;
  assign pc_en     = w.pc_en;
  assign mar_en    = w.mar_en;
  assign inst1_en  = w.inst1_en;
  assign inst2_en  = w.inst2_en;
  assign rc_en     = w.rc_en;
  assign mem_we    = w.mem_we;
  assign branch_en = w.branch_en;
  assign x1_sel    = w.x1_sel;
  assign x2_sel    = w.x2_sel;
  assign mar_sel   = w.mar_sel;
  assign y_sel     = w.y_sel;

  // R5: a single write pulse, preceded by the effective-address load
  p_wstrobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_wstrobe_after_mar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mar_en && mar_sel));

  // R6: branch enable only follows a subtract compare with PC into X1
  p_branch_after_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    branch_en |-> $past(alu_fn == FN_SUB && x1_en && x1_sel));

  // R7: every fetch of the next byte advances PC and MAR
  p_fetch_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inst1_en |-> (pc_en && mar_en && !mar_sel));

  // R8: register writes always target the rc field
  p_write_rc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_sel == RS_C));

  // R3: an ALU result load follows the cycle that latched X2 and rc
  p_alu_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (y_en && !y_sel) |-> $past(x2_en && rc_en));

endmodule

// File: tb/ctl_sequencer_tb_top.sv
module ctl_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op1 = 2'd0;
  logic [1:0] op2 = 2'd0;
  logic       reg_we, x1_en, x2_en, y_en, pc_en, mar_en, inst1_en, inst2_en;
  logic       rc_en, mem_we, branch_en, x1_sel, x2_sel, mar_sel, y_sel;
  logic [1:0] reg_sel, alu_fn;

  int  n_run = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  ctl_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .op1(op1), .op2(op2),
    .reg_we(reg_we), .reg_sel(reg_sel), .alu_fn(alu_fn),
    .x1_en(x1_en), .x2_en(x2_en), .y_en(y_en), .pc_en(pc_en),
    .mar_en(mar_en), .inst1_en(inst1_en), .inst2_en(inst2_en),
    .rc_en(rc_en), .mem_we(mem_we), .branch_en(branch_en),
    .x1_sel(x1_sel), .x2_sel(x2_sel), .mar_sel(mar_sel), .y_sel(y_sel)
  );

  localparam logic [18:0] WE  = 19'h40000, SRB = 19'h10000, SRC = 19'h20000;
  localparam logic [18:0] FSB = 19'h04000, FNR = 19'h08000;
  localparam logic [18:0] X1  = 19'h02000, X2  = 19'h01000, YE  = 19'h00800;
  localparam logic [18:0] PC  = 19'h00400, MA  = 19'h00200, I1  = 19'h00100;
  localparam logic [18:0] I2  = 19'h00080, RC  = 19'h00040, MW  = 19'h00020;
  localparam logic [18:0] BR  = 19'h00010, X1S = 19'h00008, X2S = 19'h00004;
  localparam logic [18:0] MAS = 19'h00002, YS  = 19'h00001;
  localparam logic [18:0] ADV = PC | MA;
  localparam logic [18:0] NXT = I1 | ADV;

  function automatic logic [26:0] row(input logic [3:0] rq, input logic [3:0] op,
                                      input logic [18:0] wd);
    return {rq, op, wd};
  endfunction

  localparam int NV = 37;
  localparam logic [26:0] VEC [NV] = '{
    row(4'd1,  4'b0000, NXT),            row(4'd1,  4'b0000, 19'h0),
    row(4'd11, 4'b1101, X1),             row(4'd11, 4'b1110, X2|RC|SRB),
    row(4'd11, 4'b0110, YE|NXT),         row(4'd8,  4'b0100, WE|SRC),
    row(4'd3,  4'b1100, X1),             row(4'd3,  4'b0000, X2|RC|SRB),
    row(4'd3,  4'b1010, YE|FSB|NXT),     row(4'd2,  4'b1000, WE|SRC),
    row(4'd3,  4'b0000, X1),             row(4'd3,  4'b0100, X2|RC|SRB),
    row(4'd3,  4'b0000, YE|FNR|NXT),     row(4'd2,  4'b1100, WE|SRC),
    row(4'd4,  4'b0000, X1|I2),          row(4'd4,  4'b0000, X2|X2S|RC),
    row(4'd4,  4'b0000, MA|MAS),         row(4'd4,  4'b0000, YE|YS|ADV),
    row(4'd7,  4'b0000, NXT),            row(4'd4,  4'b1101, WE|SRC),
    row(4'd5,  4'b0000, X1|I2),          row(4'd5,  4'b0000, X2|X2S),
    row(4'd5,  4'b0000, MA|MAS|X2|SRC),  row(4'd5,  4'b0000, MW|ADV),
    row(4'd5,  4'b0000, NXT),            row(4'd9,  4'b1110, 19'h0),
    row(4'd6,  4'b0000, X1|I2),          row(4'd6,  4'b0000, X2|SRB),
    row(4'd6,  4'b0000, FSB|X1|X1S|X2|X2S), row(4'd6, 4'b0000, BR),
    row(4'd6,  4'b0000, ADV),            row(4'd7,  4'b0000, NXT),
    row(4'd9,  4'b1111, 19'h0),
    row(4'd10, 4'b0000, ADV),            row(4'd10, 4'b0000, NXT),
    row(4'd10, 4'b0000, 19'h0),
    row(4'd2,  4'b0000, X1)
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [18:0] word_now();
    return {reg_we, reg_sel, alu_fn, x1_en, x2_en, y_en, pc_en, mar_en,
            inst1_en, inst2_en, rc_en, mem_we, branch_en,
            x1_sel, x2_sel, mar_sel, y_sel};
  endfunction

  task automatic check(input string rq, input logic [18:0] exp);
    logic [18:0] got;
    got = word_now();
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s word got %05h expected %05h", rq, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", NXT);                       // fetch word during reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      check(tag(VEC[i][26:23]), VEC[i][18:0]);
      {op1, op2} = VEC[i][22:19];
      @(negedge clk);
    end
    // now in the second ALU cycle of the final add; reset mid-run
    rst_n = 1'b0;
    #2;
    check("R1", NXT);                       // asynchronous entry to fetch
    @(negedge clk);
    check("R1", NXT);
    rst_n = 1'b1;
    check("R1", NXT);
    {op1, op2} = 4'b0100;
    @(negedge clk);
    check("R1", 19'h0);                     // idle dispatch after fetch
    {op1, op2} = 4'b0111;                   // R2: op1=01 selects ALU, op2 ignored
    @(negedge clk);
    check("R2", X1);
    {op1, op2} = 4'b1000;                   // R11: changed op1 mid-run
    @(negedge clk);
    check("R11", X2|RC|SRB);
    @(negedge clk);
    check("R11", YE|FSB|NXT);               // still subtract
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule